// File: doc/BRIEF.md
# Segmented indirect-access word buffer

This block is a 48-word store that a host processor and a serial queue engine share. The host cannot address the words directly. It loads a 6-bit pointer and then moves words through a single data request channel. After every accepted data access the pointer advances by one, so a block of words can be streamed without reloading it. The store has three segments of 16 words each. Each segment has a fixed direction for the host:

| Addresses | Segment | Host may | Engine may |
|---|---|---|---|
| 0x00-0x0F | receive | read | write or read |
| 0x10-0x1F | transmit | write | read |
| 0x20-0x2F | command | write | read |
| 0x30-0x3F | none | nothing | nothing |

The engine has its own port. It reads queued transmit and command words and deposits received words. Both ports share one physical memory port, and the engine always takes the cycle. The host data channel is valid/ready. A request is taken on a clock edge where `hst_req_valid` and `hst_req_ready` are both high. While ready is low the host must hold valid, write and write data unchanged. Read results come back one cycle after acceptance as a single-cycle `hst_rsp_valid` pulse, with no back-pressure. The host must take the result in that cycle. The array is not cleared by reset.

Top module: `seg_buffer_ram`

## Requirements
- R1: After reset, `hst_addr` is 0, `hst_acc_err` is 0, and neither `hst_rsp_valid` nor `eng_rsp_valid` is asserted.
- R2: A host write accepted at an address in 0x10-0x1F stores the full 16-bit word. An engine read of that address (`eng_valid`=1, `eng_write`=0) returns it on `eng_rsp_rdata` in the next cycle, with `eng_rsp_valid`=1.
- R3: A word written by the engine at 0x00-0x0F is returned to a host read of that address in the cycle after acceptance, with `hst_rsp_valid`=1 for exactly that cycle.
- R4: Every accepted host data access increments `hst_addr` by one, wrapping from 0x3F to 0x00. `hst_addr_load` sets the pointer to `hst_addr_value`. When a load coincides with an accepted access, the access uses the old pointer and the load value wins.
- R5: A host write to 0x00-0x0F or to 0x30-0x3F is dropped, leaving the stored word unchanged, and sets `hst_acc_err`.
- R6: A host read of 0x10-0x3F produces a response of 0 and sets `hst_acc_err`.
- R7: `hst_acc_err` stays set until `hst_err_clear` is pulsed. A new error in the same cycle as the clear leaves it set.
- R8: `hst_req_ready` is low exactly in cycles with `eng_valid` high. A stalled host request neither accesses memory nor moves the pointer.
- R9: A host write to 0x20-0x2F keeps only bits 7:0. An engine read of such a word returns bits 15:8 as 0.
- R10: An engine write outside 0x00-0x0F is dropped. An engine read of 0x30-0x3F returns 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| hst_addr_load | input | 1 | Load the host pointer |
| hst_addr_value | input | 6 | Value to load into the pointer |
| hst_addr | output | 6 | Current host pointer |
| hst_req_valid | input | 1 | Host data request valid |
| hst_req_ready | output | 1 | Host request accepted this cycle if valid |
| hst_req_write | input | 1 | 1 = write, 0 = read |
| hst_req_wdata | input | 16 | Host write word |
| hst_rsp_valid | output | 1 | Host read result valid (one cycle) |
| hst_rsp_rdata | output | 16 | Host read result |
| hst_acc_err | output | 1 | Sticky direction/range error flag |
| hst_err_clear | input | 1 | Clear the error flag |
| eng_valid | input | 1 | Engine access this cycle |
| eng_write | input | 1 | 1 = engine write, 0 = engine read |
| eng_addr | input | 6 | Engine word address |
| eng_wdata | input | 16 | Engine write word |
| eng_rsp_valid | output | 1 | Engine read result valid |
| eng_rsp_rdata | output | 16 | Engine read result |

## Verification
The first set of patterns is directed. The engine fills the receive segment, and the host then streams writes through the transmit and command segments in one pass. This separates per-segment masking and the pointer increment from a plain store. Single accesses at 0x30, 0x3F and 0x0x addresses, together with a load on the same cycle as an access and a clear on the same cycle as an error, tell dropped accesses, wrap-around and precedence rules apart from a merely permissive design. Constrained random traffic then overlaps engine and host requests, so stalls, held requests and interleaved responses are compared against a bench model of the memory, pointer and flag.

// File: rtl/segbuf_pkg.sv
package segbuf_pkg;
  // Segment identity, derived from the upper pointer bits.
  typedef enum logic [1:0] {
    SEG_RX   = 2'd0,
    SEG_TX   = 2'd1,
    SEG_CMD  = 2'd2,
    SEG_NONE = 2'd3
  } seg_e;
endpackage

// File: rtl/segbuf_decode.sv
module segbuf_decode
  import segbuf_pkg::*;
#(
  parameter int ADDR_W  = 6,
  parameter int OFS_W   = 4,
  parameter bit IS_HOST = 1'b1
) (
  input  logic [ADDR_W-1:0] addr,
  input  logic              is_write,
  output logic              allowed,
  output logic              is_cmd
);
  localparam int SEL_W = ADDR_W - OFS_W;

  logic [SEL_W-1:0] sel;
  seg_e             seg;

  assign sel = addr[ADDR_W-1:OFS_W];

  always_comb begin
    case (int'(sel))
      0:       seg = SEG_RX;
      1:       seg = SEG_TX;
      2:       seg = SEG_CMD;
      default: seg = SEG_NONE;
    endcase
  end

  assign is_cmd = (seg == SEG_CMD);

  // Direction rules differ by port; pick the variant at elaboration.
  generate
    if (IS_HOST) begin : g_host
      assign allowed = is_write ? (seg == SEG_TX || seg == SEG_CMD)
                                : (seg == SEG_RX);
    end else begin : g_eng
      assign allowed = is_write ? (seg == SEG_RX) : (seg != SEG_NONE);
    end
  endgenerate
endmodule

// File: rtl/segbuf_store.sv
module segbuf_store #(
  parameter int DATA_W = 16,
  parameter int WORDS  = 48,
  parameter int ADDR_W = 6
) (
  input  logic              clk,
  input  logic              en,
  input  logic              we,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] rdata
);
  // Contents are left undefined by reset on purpose.
  logic [DATA_W-1:0] mem [WORDS];

  always_ff @(posedge clk) begin
    if (en) begin
      if (we) mem[addr] <= wdata;
      else    rdata     <= mem[addr];
    end
  end
endmodule

// File: rtl/seg_buffer_ram.sv
module seg_buffer_ram #(
  parameter int DATA_W    = 16,
  parameter int SEG_DEPTH = 16,
  parameter int CMD_W     = 8
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        hst_addr_load,
  input  logic [5:0]  hst_addr_value,
  output logic [5:0]  hst_addr,
  input  logic        hst_req_valid,
  output logic        hst_req_ready,
  input  logic        hst_req_write,
  input  logic [15:0] hst_req_wdata,
  output logic        hst_rsp_valid,
  output logic [15:0] hst_rsp_rdata,
  output logic        hst_acc_err,
  input  logic        hst_err_clear,
  input  logic        eng_valid,
  input  logic        eng_write,
  input  logic [5:0]  eng_addr,
  input  logic [15:0] eng_wdata,
  output logic        eng_rsp_valid,
  output logic [15:0] eng_rsp_rdata
);
  localparam int NUM_SEG = 3;
  localparam int WORDS   = NUM_SEG * SEG_DEPTH;
  localparam int ADDR_W  = $clog2(WORDS);
  localparam int OFS_W   = $clog2(SEG_DEPTH);
  localparam logic [DATA_W-1:0] CMD_MASK = {{(DATA_W-CMD_W){1'b0}}, {CMD_W{1'b1}}};

  logic [ADDR_W-1:0] addr_q;
  logic              host_acc, h_ok, h_is_cmd, e_ok, e_is_cmd;
  logic              m_en, m_we;
  logic [ADDR_W-1:0] m_addr;
  logic [DATA_W-1:0] m_wdata, st_rdata;
  logic              h_rsp_v, h_rsp_zero, e_rsp_v, e_rsp_zero, err_q;

  // Engine owns the shared port whenever it asks.
  assign hst_req_ready = !eng_valid;
  assign host_acc      = hst_req_valid && hst_req_ready;

  segbuf_decode #(.ADDR_W(ADDR_W), .OFS_W(OFS_W), .IS_HOST(1'b1)) u_hdec (
    .addr(addr_q), .is_write(hst_req_write), .allowed(h_ok), .is_cmd(h_is_cmd)
  );

  segbuf_decode #(.ADDR_W(ADDR_W), .OFS_W(OFS_W), .IS_HOST(1'b0)) u_edec (
    .addr(eng_addr), .is_write(eng_write), .allowed(e_ok), .is_cmd(e_is_cmd)
  );

  always_comb begin
    if (eng_valid) begin
      m_en    = e_ok;
      m_we    = eng_write;
      m_addr  = eng_addr;
      m_wdata = eng_wdata;
    end else begin
      m_en    = host_acc && h_ok;
      m_we    = hst_req_write;
      m_addr  = addr_q;
      m_wdata = h_is_cmd ? (hst_req_wdata & CMD_MASK) : hst_req_wdata;
    end
  end

  segbuf_store #(.DATA_W(DATA_W), .WORDS(WORDS), .ADDR_W(ADDR_W)) u_store (
    .clk(clk), .en(m_en), .we(m_we), .addr(m_addr), .wdata(m_wdata), .rdata(st_rdata)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      addr_q     <= '0;
      err_q      <= 1'b0;
      h_rsp_v    <= 1'b0;
      h_rsp_zero <= 1'b0;
      e_rsp_v    <= 1'b0;
      e_rsp_zero <= 1'b0;
    end else begin
      if (hst_addr_load)  addr_q <= hst_addr_value;
      else if (host_acc)  addr_q <= addr_q + 1'b1;

      if (host_acc && !h_ok) err_q <= 1'b1;
      else if (hst_err_clear) err_q <= 1'b0;

      h_rsp_v    <= host_acc && !hst_req_write;
      h_rsp_zero <= !h_ok;
      e_rsp_v    <= eng_valid && !eng_write;
      e_rsp_zero <= !e_ok;
    end
  end

  assign hst_addr      = addr_q;
  assign hst_acc_err   = err_q;
  assign hst_rsp_valid = h_rsp_v;
  assign hst_rsp_rdata = h_rsp_zero ? '0 : st_rdata;
  assign eng_rsp_valid = e_rsp_v;
  assign eng_rsp_rdata = e_rsp_zero ? '0 : st_rdata;

  // R4: accepted access without a load steps the pointer by one
  a_r4_addr_step: assert property (@(posedge clk) disable iff (!rst_n)
    (hst_req_valid && hst_req_ready && !hst_addr_load) |=> hst_addr == $past(hst_addr) + 1'b1);

  // R8: a stalled request leaves the pointer alone
  a_r8_stall_holds_addr: assert property (@(posedge clk) disable iff (!rst_n)
    (eng_valid && hst_req_valid && !hst_addr_load) |=> $stable(hst_addr));

  // R3: a host response only follows an accepted read
  a_r3_rsp_after_read: assert property (@(posedge clk) disable iff (!rst_n)
    hst_rsp_valid |-> $past(hst_req_valid && hst_req_ready && !hst_req_write));

  // R6: a denied read answers with zero
  a_r6_denied_read_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (host_acc && !hst_req_write && !h_ok) |=> (hst_rsp_valid && hst_rsp_rdata == '0));

  // R5: a denied write raises the flag
  a_r5_denied_write_flag: assert property (@(posedge clk) disable iff (!rst_n)
    (host_acc && hst_req_write && !h_ok) |=> hst_acc_err);

  // R7: the flag holds without a clear
  a_r7_err_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (hst_acc_err && !hst_err_clear) |=> hst_acc_err);

  // R9: command words come back with a clear upper byte
  a_r9_cmd_upper_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (eng_valid && !eng_write && e_is_cmd) |=> eng_rsp_rdata[DATA_W-1:CMD_W] == '0);
endmodule

// File: tb/test_seg_buffer_ram.sv
`timescale 1ns/1ps
module test_seg_buffer_ram;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        hst_addr_load = 1'b0;
  logic [5:0]  hst_addr_value = '0;
  logic [5:0]  hst_addr;
  logic        hst_req_valid = 1'b0;
  logic        hst_req_ready;
  logic        hst_req_write = 1'b0;
  logic [15:0] hst_req_wdata = '0;
  logic        hst_rsp_valid;
  logic [15:0] hst_rsp_rdata;
  logic        hst_acc_err;
  logic        hst_err_clear = 1'b0;
  logic        eng_valid = 1'b0;
  logic        eng_write = 1'b0;
  logic [5:0]  eng_addr = '0;
  logic [15:0] eng_wdata = '0;
  logic        eng_rsp_valid;
  logic [15:0] eng_rsp_rdata;

  always #4 clk = ~clk;

  seg_buffer_ram i_seg_buffer_ram (
    .clk(clk), .rst_n(rst_n),
    .hst_addr_load(hst_addr_load), .hst_addr_value(hst_addr_value), .hst_addr(hst_addr),
    .hst_req_valid(hst_req_valid), .hst_req_ready(hst_req_ready),
    .hst_req_write(hst_req_write), .hst_req_wdata(hst_req_wdata),
    .hst_rsp_valid(hst_rsp_valid), .hst_rsp_rdata(hst_rsp_rdata),
    .hst_acc_err(hst_acc_err), .hst_err_clear(hst_err_clear),
    .eng_valid(eng_valid), .eng_write(eng_write), .eng_addr(eng_addr),
    .eng_wdata(eng_wdata), .eng_rsp_valid(eng_rsp_valid), .eng_rsp_rdata(eng_rsp_rdata)
  );

  int checks = 0;
  int failures = 0;
  bit done = 0;

  // Bench model
  logic [15:0] m_mem [48];
  bit          m_known [48];
  int          m_addr = 0;
  bit          m_err = 0;
  bit          x_hrv = 0, x_hchk = 0, x_erv = 0, x_echk = 0;
  logic [15:0] x_hrd = '0, x_erd = '0;
  string       x_htag = "R3", x_etag = "R2";

  task automatic chk(string tag, int act, int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  function automatic logic [15:0] host_store_val(int a, logic [15:0] d);
    return (a >= 32) ? {8'h00, d[7:0]} : d;
  endfunction

  function automatic bit host_may(int a, bit w);
    return w ? (a >= 16 && a < 48) : (a < 16);
  endfunction

  task automatic check_outputs();
    chk("R4 pointer", hst_addr, m_addr);
    chk("R7 error flag", hst_acc_err, m_err);
    chk("R3 host rsp valid", hst_rsp_valid, x_hrv);
    if (x_hrv && x_hchk) chk(x_htag, hst_rsp_rdata, x_hrd);
    chk("R2 eng rsp valid", eng_rsp_valid, x_erv);
    if (x_erv && x_echk) chk(x_etag, eng_rsp_rdata, x_erd);
  endtask

  task automatic step(bit ev, bit ew, int ea, logic [15:0] ed,
                      bit hv, bit hw, logic [15:0] hd, bit al, int av, bit ec);
    int  a;
    bit  acc, seterr;
    @(negedge clk);
    check_outputs();
    eng_valid = ev; eng_write = ew; eng_addr = 6'(ea); eng_wdata = ed;
    hst_req_valid = hv; hst_req_write = hw; hst_req_wdata = hd;
    hst_addr_load = al; hst_addr_value = 6'(av); hst_err_clear = ec;
    #1;
    chk("R8 ready", hst_req_ready, !ev);
    a = m_addr; acc = hv && !ev; seterr = 0;
    x_hrv = 0; x_hchk = 0; x_erv = 0; x_echk = 0;
    if (ev) begin
      if (ew) begin
        if (ea < 16) begin m_mem[ea] = ed; m_known[ea] = 1; end
      end else begin
        x_erv = 1;
        if (ea >= 48) begin x_erd = '0; x_echk = 1; x_etag = "R10 eng read out of range"; end
        else if (m_known[ea]) begin
          x_erd = m_mem[ea]; x_echk = 1;
          x_etag = (ea >= 32) ? "R9 eng read cmd" : "R2 eng read data";
        end
      end
    end
    if (acc) begin
      if (hw) begin
        if (host_may(a, 1)) begin m_mem[a] = host_store_val(a, hd); m_known[a] = 1; end
        else seterr = 1;
      end else begin
        x_hrv = 1;
        if (host_may(a, 0)) begin
          if (m_known[a]) begin x_hrd = m_mem[a]; x_hchk = 1; x_htag = "R3 host read rx"; end
        end else begin
          x_hrd = '0; x_hchk = 1; x_htag = "R6 denied read"; seterr = 1;
        end
      end
    end
    if (seterr) m_err = 1; else if (ec) m_err = 0;
    if (al) m_addr = av; else if (acc) m_addr = (a + 1) % 64;
  endtask

  task automatic idle();
    step(0, 0, 0, 16'h0, 0, 0, 16'h0, 0, 0, 0);
  endtask

  initial begin
    bit          hv, hw, ev, pend;
    logic [15:0] hd;
    void'($urandom(32'd2024));
    for (int i = 0; i < 48; i++) begin m_known[i] = 0; m_mem[i] = '0; end
    repeat (3) @(posedge clk);
    @(negedge clk); rst_n = 1'b1;
    // R1: reset state
    chk("R1 pointer", hst_addr, 0);
    chk("R1 error flag", hst_acc_err, 0);
    chk("R1 host rsp", hst_rsp_valid, 0);
    chk("R1 eng rsp", eng_rsp_valid, 0);

    // Engine fills the receive segment
    for (int i = 0; i < 16; i++) step(1, 1, i, 16'hA000 + 16'(i), 0, 0, 0, 0, 0, 0);
    // R2/R9: host streams transmit then command words
    step(0, 0, 0, 0, 0, 0, 0, 1, 16, 0);
    for (int i = 0; i < 32; i++) step(0, 0, 0, 0, 1, 1, 16'h5A00 + 16'(i * 257), 0, 0, 0);
    // R5: write at 0x30 dropped, R6: read at 0x31 is zero
    step(0, 0, 0, 0, 1, 1, 16'hBEEF, 0, 0, 0);
    step(0, 0, 0, 0, 0, 0, 0, 0, 0, 1);
    step(0, 0, 0, 0, 1, 0, 0, 0, 0, 0);
    // R4: wrap from 0x3F to 0x00
    step(0, 0, 0, 0, 0, 0, 0, 1, 63, 1);
    step(0, 0, 0, 0, 1, 0, 0, 0, 0, 0);
    // R3: stream reads of the receive segment
    for (int i = 0; i < 4; i++) step(0, 0, 0, 0, 1, 0, 0, 0, 0, 0);
    // R4: load coincides with an access (read of 4, pointer goes to 5)
    step(0, 0, 0, 0, 1, 0, 0, 1, 5, 0);
    // R5: host write into receive is dropped, stored word survives
    step(0, 0, 0, 0, 1, 1, 16'hDEAD, 0, 0, 0);
    step(0, 0, 0, 0, 1, 0, 0, 1, 5, 0);
    step(0, 0, 0, 0, 1, 0, 0, 0, 0, 0);
    // R7: new error wins over a clear, then a clear alone works
    step(0, 0, 0, 0, 0, 0, 0, 1, 2, 1);
    step(0, 0, 0, 0, 1, 1, 16'h1111, 0, 0, 1);
    step(0, 0, 0, 0, 0, 0, 0, 0, 0, 1);
    // R9: engine read of command word; R10: engine write into transmit dropped
    step(1, 0, 33, 0, 0, 0, 0, 0, 0, 0);
    step(1, 1, 16, 16'h7777, 0, 0, 0, 0, 0, 0);
    step(1, 0, 16, 0, 0, 0, 0, 0, 0, 0);
    step(1, 0, 50, 0, 0, 0, 0, 0, 0, 0);
    // R8: host request stalled by engine, then held and accepted
    step(1, 0, 17, 0, 1, 0, 0, 1, 0, 0);
    step(0, 0, 0, 0, 1, 0, 0, 0, 0, 0);
    idle();

    // Constrained random traffic
    pend = 0; hv = 0; hw = 0; hd = '0;
    for (int n = 0; n < 3000; n++) begin
      ev = ($urandom % 4) == 0;
      if (!pend) begin
        hv = ($urandom % 2) == 1;
        hw = ($urandom % 2) == 1;
        hd = 16'($urandom);
      end
      step(ev, ($urandom % 2) == 1, int'($urandom % 64), 16'($urandom),
           hv, hw, hd, ($urandom % 8) == 0, int'($urandom % 64), ($urandom % 16) == 0);
      pend = hv && ev;
    end
    idle();
    idle();
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++;
      failures++;
      $display("FAIL watchdog expired (R1..R10 run incomplete)");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule